// File: doc/BRIEF.md
# Machine-Cycle Timer with 16-bit and 8-bit Reload Modes

This block is an up-counting timer that advances once per machine cycle, where a machine cycle lasts a fixed number of clocks (`DIV`, default 12). Its two count bytes form either a single 16-bit counter that wraps to zero, or an 8-bit counter in the low byte that reloads itself from the high byte every time it wraps. A run bit gates counting, and a mode bit picks between the two behaviours.

Every wrap sets an overflow flag. The flag drives the interrupt request output. It stays set until the interrupt is acknowledged or software clears it through the register port. Every wrap also produces a one-clock pulse on a separate output. In reload mode that pulse acts as a periodic rate tick, for example for a serial port's bit clock. Software reaches both count bytes and a small control register through a simple write port and a combinational read port.

Top module: `mc_timer`

## Requirements
- R1: While running, the count advances exactly once in every `DIV` consecutive clocks, so a run window of N×DIV clocks advances it by exactly N steps.
- R2: In wide mode (control bit 1 = 0), the high and low bytes form one 16-bit up-counter with carry from low to high. A step from 0xFFFF gives 0x0000 and counts as an overflow.
- R3: In reload mode (control bit 1 = 1), only the low byte counts. A step from 0xFF loads the low byte with the high byte's value and counts as an overflow. The high byte never changes in this mode.
- R4: While the run bit (control bit 0) is 0, both count bytes hold their values.
- R5: An overflow sets the flag, and `irq` equals the flag. The flag stays set until it is cleared.
- R6: A one-clock `irq_ack` clears the flag. If an overflow occurs in the same clock, the flag stays set.
- R7: A control write with bit 2 = 0 clears the flag. A control write with bit 2 = 1 leaves the flag unchanged, and software can never set it.
- R8: Every overflow produces exactly one one-clock pulse on `ovf_tick`, which appears in the same clock that the flag rises. This happens even if the flag is already set.
- R9: Register addresses: 0 = low byte, 1 = high byte, 2 = control {bit 2 flag, bit 1 mode, bit 0 run}, 3 = reads zero. `rd_data` follows `rd_addr` combinationally.
- R10: A write to a count byte takes priority over a step in the same clock. That clock neither advances the count nor produces an overflow. The written value is visible on the next read.
- R11: After reset, both count bytes, the run bit, the mode bit, the flag and `ovf_tick` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address of the write |
| wr_data | input | BYTE_W | Write data |
| rd_addr | input | 2 | Register address of the read |
| rd_data | output | BYTE_W | Read data of the selected register |
| irq_ack | input | 1 | Interrupt acknowledge; clears the flag |
| irq | output | 1 | Interrupt request (the overflow flag) |
| ovf_tick | output | 1 | One-clock pulse per overflow |

## Verification
The bench targets four kinds of corner case:

- **Carry and wrap.** Carry across the byte boundary and the 0xFFFF wrap. A design that failed to carry would read back 0x1201 instead of 0x1301, and one that wrapped wrongly would leave the flag clear.
- **Reload edges.** A reload value of 0xFF overflows on every step, and a reload value of 0xFE overflows on every second step. A design that reloaded with zero, or changed the high byte, would show a low byte or pulse count off the expected one.
- **Priority in the same clock.** Count-byte writes on every clock of a run must freeze the count and suppress overflow, so a design that let the step win would raise `irq`.
- **Flag clearing.** Both acknowledge paths are exercised, together with the no-effect write of bit 2 = 1. A design that let software set the flag, or ignored the acknowledge, would show the wrong `irq` level.

// File: rtl/mc_timer_pkg.sv
package mc_timer_pkg;

   typedef enum logic [1:0] {
      REG_LOW  = 2'd0,
      REG_HIGH = 2'd1,
      REG_CTRL = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic {
      MODE_WIDE   = 1'b0,
      MODE_RELOAD = 1'b1
   } tmr_mode_e;

   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_MODE_BIT = 1;
   localparam int CTRL_FLAG_BIT = 2;

endpackage

// File: rtl/mc_timer_prescale.sv
module mc_timer_prescale #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   localparam int  PW      = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  IS_POW2 = (DIV & (DIV - 1)) == 0;

   logic [PW-1:0] phase_q;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("mc_timer_prescale: DIV must be at least 2");
      end

      if (IS_POW2) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) phase_q <= '0;
            else        phase_q <= phase_q + PW'(1);
         end
         assign tick = &phase_q;
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       phase_q <= '0;
            else if (phase_q == PW'(DIV - 1)) phase_q <= '0;
            else                              phase_q <= phase_q + PW'(1);
         end
         assign tick = (phase_q == PW'(DIV - 1));
      end
   endgenerate

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick) else $error("tick on consecutive clocks"); // R1

endmodule

// File: rtl/mc_timer_core.sv
module mc_timer_core
   import mc_timer_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              mode,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] lo_o,
   output logic [BYTE_W-1:0] hi_o,
   output logic              wrap_o
);

   localparam int CW = 2 * BYTE_W;

   generate
      if (BYTE_W < 3) begin : g_bad_width
         $error("mc_timer_core: BYTE_W must be at least 3");
      end
   endgenerate

   logic [BYTE_W-1:0] lo_q, hi_q;
   logic [CW-1:0]     cnt;
   logic              any_wr, at_max_wide, at_max_byte;

   assign cnt         = {hi_q, lo_q};
   assign any_wr      = wr_lo | wr_hi;
   assign at_max_wide = &cnt;
   assign at_max_byte = &lo_q;
   assign wrap_o      = step && !any_wr &&
                        ((mode == MODE_RELOAD) ? at_max_byte : at_max_wide);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (any_wr) begin
         if (wr_lo) lo_q <= wr_data;
         if (wr_hi) hi_q <= wr_data;
      end else if (step) begin
         if (mode == MODE_RELOAD) begin
            lo_q <= at_max_byte ? hi_q : lo_q + BYTE_W'(1);
         end else begin
            {hi_q, lo_q} <= cnt + CW'(1);
         end
      end
   end

   assign lo_o = lo_q;
   assign hi_o = hi_q;

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !any_wr) |=> $stable({hi_o, lo_o})) else $error("count moved while idle"); // R4

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_o && mode == MODE_WIDE) |=> ({hi_o, lo_o} == '0)) else $error("wide wrap not zero"); // R2

   AST_RELOAD_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_o && mode == MODE_RELOAD) |=> (lo_o == $past(hi_o)) && $stable(hi_o)) else $error("bad reload"); // R3

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (lo_o == $past(wr_data))) else $error("write lost"); // R10

endmodule

// File: rtl/mc_timer_flag.sv
module mc_timer_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ack_i,
   input  logic sw_clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag_o <= 1'b0;
      else if (set_i)             flag_o <= 1'b1;
      else if (ack_i || sw_clr_i) flag_o <= 1'b0;
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o) else $error("flag not set"); // R5

   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(set_i)) else $error("flag rose without overflow"); // R7

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !set_i) |=> !flag_o) else $error("ack did not clear"); // R6

   AST_SW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clr_i && !set_i) |=> !flag_o) else $error("software clear failed"); // R7

endmodule

// File: rtl/mc_timer.sv
module mc_timer
   import mc_timer_pkg::*;
#(
   parameter int DIV    = 12,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              irq_ack,
   output logic              irq,
   output logic              ovf_tick
);

   logic       tick, run_q, mode_q, wrap, flag, pulse_q;
   logic       wr_lo, wr_hi, wr_ctrl, sw_clr;
   logic [BYTE_W-1:0] lo, hi;
   reg_sel_e   wsel, rsel;

   assign wsel    = reg_sel_e'(wr_addr);
   assign rsel    = reg_sel_e'(rd_addr);
   assign wr_lo   = wr_en && (wsel == REG_LOW);
   assign wr_hi   = wr_en && (wsel == REG_HIGH);
   assign wr_ctrl = wr_en && (wsel == REG_CTRL);
   assign sw_clr  = wr_ctrl && !wr_data[CTRL_FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         mode_q <= 1'b0;
      end else if (wr_ctrl) begin
         run_q  <= wr_data[CTRL_RUN_BIT];
         mode_q <= wr_data[CTRL_MODE_BIT];
      end
   end

   mc_timer_prescale #(.DIV(DIV)) i_prescale (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   mc_timer_core #(.BYTE_W(BYTE_W)) i_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (tick & run_q),
      .mode    (mode_q),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wr_data (wr_data),
      .lo_o    (lo),
      .hi_o    (hi),
      .wrap_o  (wrap)
   );

   mc_timer_flag i_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (wrap),
      .ack_i    (irq_ack),
      .sw_clr_i (sw_clr),
      .flag_o   (flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= wrap;
   end

   always_comb begin
      unique case (rsel)
         REG_LOW:  rd_data = lo;
         REG_HIGH: rd_data = hi;
         REG_CTRL: rd_data = BYTE_W'({flag, mode_q, run_q});
         default:  rd_data = '0;
      endcase
   end

   assign irq      = flag;
   assign ovf_tick = pulse_q;

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_tick |=> !ovf_tick) else $error("pulse wider than one clock"); // R8

   AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_tick |-> irq) else $error("pulse without flag"); // R8

   AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wr_lo && !wr_hi) |=> $stable({hi, lo})) else $error("moved while stopped"); // R4

endmodule

// File: tb/test_mc_timer.sv
module test_mc_timer;

   localparam int DIV = 12;
   localparam int BW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [BW-1:0] wr_data = '0;
   logic [1:0]    rd_addr = '0;
   logic [BW-1:0] rd_data;
   logic          irq_ack = 1'b0;
   logic          irq, ovf_tick;

   int n_chk = 0;
   int n_bad = 0;
   int pulses = 0;
   bit done = 0;

   always #5 clk = ~clk;

   mc_timer #(.DIV(DIV), .BYTE_W(BW)) i_mc_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_ack(irq_ack), .irq(irq), .ovf_tick(ovf_tick)
   );

   always @(negedge clk) if (rst_n && ovf_tick) pulses++;

   // {mode, hi, lo, steps, exp_hi, exp_lo, exp_flag, exp_pulses}
   localparam logic [45:0] VEC [10] = '{
      {1'b0, 8'h12, 8'h34, 8'd5,  8'h12, 8'h39, 1'b0, 4'd0},
      {1'b0, 8'h12, 8'hFE, 8'd3,  8'h13, 8'h01, 1'b0, 4'd0},
      {1'b0, 8'hFF, 8'hFD, 8'd3,  8'h00, 8'h00, 1'b1, 4'd1},
      {1'b0, 8'hFF, 8'hFE, 8'd4,  8'h00, 8'h02, 1'b1, 4'd1},
      {1'b1, 8'hF0, 8'hFE, 8'd1,  8'hF0, 8'hFF, 1'b0, 4'd0},
      {1'b1, 8'hF0, 8'hFE, 8'd2,  8'hF0, 8'hF0, 1'b1, 4'd1},
      {1'b1, 8'hF0, 8'hFE, 8'd5,  8'hF0, 8'hF3, 1'b1, 4'd1},
      {1'b1, 8'hFE, 8'hFF, 8'd4,  8'hFE, 8'hFF, 1'b1, 4'd2},
      {1'b1, 8'hFF, 8'hFF, 8'd3,  8'hFF, 8'hFF, 1'b1, 4'd3},
      {1'b0, 8'h00, 8'h00, 8'd20, 8'h00, 8'h14, 1'b0, 4'd0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [BW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      rd_addr = a;
      #1 v = int'(rd_data);
   endtask

   // load, clear flag, run for exactly n machine cycles, stop (flag kept)
   task automatic run_for(input logic m, input logic [7:0] h, input logic [7:0] l, input int n);
      wr(2'd2, {5'b0, 1'b0, m, 1'b0});
      wr(2'd0, l);
      wr(2'd1, h);
      pulses = 0;
      wr(2'd2, {5'b0, 1'b1, m, 1'b1});
      repeat (n * DIV - 1) @(posedge clk);
      wr(2'd2, {5'b0, 1'b1, m, 1'b0});
      #2;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int v, lo0, hi0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      #1;
      // R11 reset state
      rd(2'd0, v); chk("R11 low after reset", v, 0);
      rd(2'd1, v); chk("R11 high after reset", v, 0);
      rd(2'd2, v); chk("R11 ctrl after reset", v, 0);
      chk("R11 irq after reset", int'(irq), 0);
      chk("R11 ovf_tick after reset", int'(ovf_tick), 0);

      // vector table: R1 R2 R3 R5 R8
      for (int i = 0; i < 10; i++) begin
         logic [45:0] e;
         e = VEC[i];
         run_for(e[45], e[44:37], e[36:29], int'(e[28:21]));
         rd(2'd1, v); chk($sformatf("R2/R3 vec%0d high", i), v, int'(e[20:13]));
         rd(2'd0, v); chk($sformatf("R1/R2/R3 vec%0d low", i), v, int'(e[12:5]));
         chk($sformatf("R5 vec%0d irq", i), int'(irq), int'(e[4]));
         chk($sformatf("R8 vec%0d pulses", i), pulses, int'(e[3:0]));
      end

      // R9 control readback and unused address
      wr(2'd2, 8'b0000_0110);
      rd(2'd2, v); chk("R9 ctrl readback", v, 8'h02);
      rd(2'd3, v); chk("R9 addr3 reads zero", v, 0);

      // R4 hold while stopped
      rd(2'd0, lo0); rd(2'd1, hi0);
      repeat (5 * DIV) @(posedge clk);
      #2;
      rd(2'd0, v); chk("R4 low held", v, lo0);
      rd(2'd1, v); chk("R4 high held", v, hi0);

      // R6 acknowledge clears
      run_for(1'b0, 8'hFF, 8'hFF, 1);
      chk("R5 flag set by wide wrap", int'(irq), 1);
      repeat (3 * DIV) @(posedge clk);
      #2 chk("R5 flag persists", int'(irq), 1);
      @(negedge clk); irq_ack = 1'b1;
      @(posedge clk); #1 irq_ack = 1'b0;
      #1 chk("R6 ack clears irq", int'(irq), 0);

      // R7 software clear and no-effect write
      run_for(1'b0, 8'hFF, 8'hFF, 1);
      wr(2'd2, 8'b0000_0100);
      #1 chk("R7 bit2=1 keeps flag", int'(irq), 1);
      wr(2'd2, 8'b0000_0000);
      #1 chk("R7 bit2=0 clears flag", int'(irq), 0);
      wr(2'd2, 8'b0000_0100);
      #1 chk("R7 bit2=1 cannot set flag", int'(irq), 0);

      // R10 continuous byte writes freeze the count
      wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
      pulses = 0;
      wr(2'd2, 8'b0000_0101);
      for (int k = 0; k < 3 * DIV; k++) wr(2'd0, 8'hFF);
      wr(2'd2, 8'b0000_0100);
      #2;
      rd(2'd0, v); chk("R10 low frozen by writes", v, 8'hFF);
      rd(2'd1, v); chk("R10 high frozen by writes", v, 8'hFF);
      chk("R10 no flag from write", int'(irq), 0);
      chk("R10 no pulse from write", pulses, 0);
      wr(2'd0, 8'h5A);
      rd(2'd0, v); chk("R10 written value visible", v, 8'h5A);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule